// File: doc/BRIEF.md
# Cascaded Fast/Slow Operand Crossbar

This block routes operands from the belt to the execution slots through two cascaded selection levels. A wide, registered slow level looks at every stored result and picks one candidate value for each operand port of each consumer slot. The narrow fast level comes one cycle later. It makes the final choice between those candidates and the one-cycle results that each producing slot delivered in the cycle before. Because of this split, a fresh result never has to pass through the wide network. The cost of the wide level grows with the number of consumer ports. The cost of the narrow level grows with the slot count.

A consumer gives its operand positions one cycle ahead. The positions are written as they will read after the current cycle's fresh results have dropped onto the belt. The slow level converts each position into the tag of a stored entry by subtracting the number of results dropping in that cycle. If the position lands among the dropping results, the slow level instead records a one-hot choice of the fresh slot, to be applied in the next cycle. Each consumer slot has a fixed operand capacity of zero, one or two. In each cycle it also gives a live operand count.

Top module: `opnd_xbar`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every op_vld bit is low and every op_data lane is zero.
- R2: Operands requested in cycle t appear on op_data/op_vld during cycle t+1. During cycle t the outputs still show the previous request.
- R3: Position 0 is the newest belt entry. When k fresh results are valid in cycle t, they take positions 0..k-1 in ascending slot index. A request for p < k returns the fresh result of rank p.
- R4: When p < k, the fresh result is returned even if a stored entry currently carries tag p.
- R5: When p >= k, the operand is the data of the valid stored entry whose tag equals p-k, whichever entry index holds it.
- R6: When a position names neither a fresh result nor a valid tagged stored entry, the operand has valid low and data zero.
- R7: Operand j (0 or 1) of a slot is live only when that slot's req_cnt exceeds j. A req_cnt of 3 behaves as 2. A non-live operand has valid low and data zero.
- R8: The capacity of slot s is the 2-bit field SLOT_CAP[2s+1:2s]. Values of 2 or more mean two operands. By default slots 0-5 take two operands and slots 6 and 7 take none. Operands at or above the capacity always have valid low and data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fresh_vld | input | NSLOT | One-cycle result valid, one bit per producing slot |
| fresh_data | input | NSLOT*DW | One-cycle result data, slot s at [s*DW +: DW] |
| store_vld | input | NSTORE | Stored entry holds a live belt value |
| store_pos | input | NSTORE*POS_W | Belt position tag of each stored entry, before this cycle's drop |
| store_data | input | NSTORE*DW | Stored entry data |
| req_cnt | input | 2*NSLOT | Live operand count per slot, slot s at [2s +: 2] |
| req_pos | input | 2*NSLOT*POS_W | Requested position, operand o=2s+j at [o*POS_W +: POS_W] |
| op_data | output | 2*NSLOT*DW | Routed operand o=2s+j at [o*DW +: DW] |
| op_vld | output | 2*NSLOT | Routed operand valid, bit o=2s+j |

## Verification
The fresh-result drop and the slow preselection fall in the same cycle whenever fresh results are valid and a request is outstanding. In that cycle every requested position must be split correctly at the boundary k between fresh ranks and shifted stored tags. Directed cycles request exactly positions k and k-1 while zero, all or some producing slots deliver. Random cycles rotate the mapping from entries to tags and mix capacities and counts. Each routed operand is compared with a bench model of the belt. The model applies the drop first and then reads the requested position.

// File: rtl/opnd_xbar_pkg.sv
package opnd_xbar_pkg;
   // operand ports per consumer slot
   localparam int OPS_PER_SLOT = 2;

   // usable operand ports for a 2-bit capacity field
   function automatic int cap_ports(input logic [1:0] cap);
      return (int'(cap) > OPS_PER_SLOT) ? OPS_PER_SLOT : int'(cap);
   endfunction
endpackage

// File: rtl/opnd_fresh_rank.sv
module opnd_fresh_rank #(
   parameter int NSLOT = 8,
   parameter int CNT_W = 4
) (
   input  logic [NSLOT-1:0]       vld,
   output logic [NSLOT*CNT_W-1:0] rank,
   output logic [CNT_W-1:0]       total
);
   // rank of slot s = number of valid fresh results in lower slots
   always_comb begin
      logic [CNT_W-1:0] acc;
      acc = '0;
      for (int s = 0; s < NSLOT; s++) begin
         rank[s*CNT_W +: CNT_W] = acc;
         acc = acc + CNT_W'(vld[s]);
      end
      total = acc;
   end
endmodule

// File: rtl/opnd_slow_sel.sv
module opnd_slow_sel #(
   parameter int NSLOT  = 8,
   parameter int NSTORE = 16,
   parameter int DW     = 32,
   parameter int POS_W  = 4,
   parameter int CNT_W  = 4,
   localparam int CW    = ((POS_W > CNT_W) ? POS_W : CNT_W) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [POS_W-1:0]        pos,
   input  logic [CNT_W-1:0]        fcnt,
   input  logic [NSLOT-1:0]        fresh_vld,
   input  logic [NSLOT*CNT_W-1:0]  rank,
   input  logic [NSTORE-1:0]       store_vld,
   input  logic [NSTORE*POS_W-1:0] store_pos,
   input  logic [NSTORE*DW-1:0]    store_data,
   output logic [NSLOT-1:0]        fsel_q,
   output logic                    hit_q,
   output logic [DW-1:0]           cand_q
);
   logic [CW-1:0]     pos_x, cnt_x;
   logic              is_fresh;
   logic [POS_W-1:0]  tag;
   logic [NSLOT-1:0]  fsel;
   logic [NSTORE-1:0] match;
   logic [DW-1:0]     cand;

   assign pos_x    = CW'(pos);
   assign cnt_x    = CW'(fcnt);
   assign is_fresh = pos_x < cnt_x;
   // position after the drop -> tag before the drop
   assign tag      = POS_W'(pos_x - cnt_x);

   always_comb begin
      for (int s = 0; s < NSLOT; s++)
         fsel[s] = en && is_fresh && fresh_vld[s] &&
                   (CW'(rank[s*CNT_W +: CNT_W]) == pos_x);
   end

   always_comb begin
      cand = '0;
      for (int e = 0; e < NSTORE; e++) begin
         match[e] = en && !is_fresh && store_vld[e] &&
                    (store_pos[e*POS_W +: POS_W] == tag);
         cand = cand | ({DW{match[e]}} & store_data[e*DW +: DW]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsel_q <= '0;
         hit_q  <= 1'b0;
         cand_q <= '0;
      end else begin
         fsel_q <= fsel;
         hit_q  <= |match;
         cand_q <= cand;
      end
   end

   // R5: live tags are unique, so at most one stored entry matches
   p_tag_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R2: a registered choice exists only for a request live last cycle
   p_sel_from_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((|fsel_q) || hit_q) |-> $past(en));
endmodule

// File: rtl/opnd_fast_mux.sv
module opnd_fast_mux #(
   parameter int NSLOT = 8,
   parameter int DW    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NSLOT*DW-1:0] fresh_q,
   input  logic [2*DW-1:0]     cand,
   input  logic [NSLOT+1:0]    sel,
   output logic [DW-1:0]       data,
   output logic                vld
);
   // narrow AND-OR over NSLOT fresh results plus two slow candidates
   always_comb begin
      data = '0;
      for (int s = 0; s < NSLOT; s++)
         data = data | ({DW{sel[s]}} & fresh_q[s*DW +: DW]);
      for (int c = 0; c < 2; c++)
         data = data | ({DW{sel[NSLOT+c]}} & cand[c*DW +: DW]);
   end
   assign vld = |sel;

   // R4: fresh and slow sources never both chosen
   p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
endmodule

// File: rtl/opnd_xbar.sv
module opnd_xbar
   import opnd_xbar_pkg::*;
#(
   parameter int NSLOT  = 8,
   parameter int DW     = 32,
   parameter int NPOS   = 16,
   parameter int NSTORE = 16,
   parameter logic [2*NSLOT-1:0] SLOT_CAP = 16'h0AAA,
   localparam int POS_W = $clog2(NPOS),
   localparam int CNT_W = $clog2(NSLOT+1),
   localparam int NOP   = NSLOT*OPS_PER_SLOT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NSLOT-1:0]        fresh_vld,
   input  logic [NSLOT*DW-1:0]     fresh_data,
   input  logic [NSTORE-1:0]       store_vld,
   input  logic [NSTORE*POS_W-1:0] store_pos,
   input  logic [NSTORE*DW-1:0]    store_data,
   input  logic [2*NSLOT-1:0]      req_cnt,
   input  logic [NOP*POS_W-1:0]    req_pos,
   output logic [NOP*DW-1:0]       op_data,
   output logic [NOP-1:0]          op_vld
);
   logic [NSLOT*CNT_W-1:0] rank;
   logic [CNT_W-1:0]       fcnt;
   logic [NSLOT*DW-1:0]    fresh_q;

   opnd_fresh_rank #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_rank (
      .vld   (fresh_vld),
      .rank  (rank),
      .total (fcnt)
   );

   // one-cycle results enter the fast level next cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fresh_q <= '0;
      else        fresh_q <= fresh_data;
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam int NUSE = cap_ports(SLOT_CAP[2*s +: 2]);

      if (NUSE == 0) begin : g_none
         logic unused_req;
         assign unused_req = ^{req_cnt[2*s +: 2],
                               req_pos[2*s*POS_W +: 2*POS_W]};
         assign op_data[2*s*DW +: 2*DW] = '0;
         assign op_vld[2*s +: 2]        = '0;
      end else begin : g_used
         logic [2*DW-1:0]    cand_q;
         logic [1:0]         hit_q;
         logic [2*NSLOT-1:0] fsel_q;

         for (genvar j = 0; j < OPS_PER_SLOT; j++) begin : g_op
            localparam int O = 2*s + j;
            if (j < NUSE) begin : g_live
               logic              en;
               logic [NSLOT+1:0]  sel;
               assign en = req_cnt[2*s +: 2] > 2'(j);

               opnd_slow_sel #(
                  .NSLOT(NSLOT), .NSTORE(NSTORE), .DW(DW),
                  .POS_W(POS_W), .CNT_W(CNT_W)
               ) u_slow (
                  .clk        (clk),
                  .rst_n      (rst_n),
                  .en         (en),
                  .pos        (req_pos[O*POS_W +: POS_W]),
                  .fcnt       (fcnt),
                  .fresh_vld  (fresh_vld),
                  .rank       (rank),
                  .store_vld  (store_vld),
                  .store_pos  (store_pos),
                  .store_data (store_data),
                  .fsel_q     (fsel_q[j*NSLOT +: NSLOT]),
                  .hit_q      (hit_q[j]),
                  .cand_q     (cand_q[j*DW +: DW])
               );

               // own slow candidate is the only slow source for this port
               assign sel = {(j == 1) ? hit_q[1] : 1'b0,
                             (j == 0) ? hit_q[0] : 1'b0,
                             fsel_q[j*NSLOT +: NSLOT]};

               opnd_fast_mux #(.NSLOT(NSLOT), .DW(DW)) u_fast (
                  .clk     (clk),
                  .rst_n   (rst_n),
                  .fresh_q (fresh_q),
                  .cand    (cand_q),
                  .sel     (sel),
                  .data    (op_data[O*DW +: DW]),
                  .vld     (op_vld[O])
               );

               // R7: a valid operand had a live count last cycle
               p_cnt_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
                  op_vld[O] |-> ($past(req_cnt[2*s +: 2]) > 2'(j)));
            end else begin : g_dead
               logic unused_pos;
               assign unused_pos   = ^req_pos[O*POS_W +: POS_W];
               assign fsel_q[j*NSLOT +: NSLOT] = '0;
               assign hit_q[j]                 = 1'b0;
               assign cand_q[j*DW +: DW]       = '0;
               assign op_data[O*DW +: DW]      = '0;
               assign op_vld[O]                = 1'b0;
            end
         end

         // R3: position 0 with slot 0 dropping yields slot 0's result
         p_fresh_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_cnt[2*s +: 2] != 2'd0 && req_pos[2*s*POS_W +: POS_W] == '0 &&
             fresh_vld[0])
            |=> (op_vld[2*s] && op_data[2*s*DW +: DW] == $past(fresh_data[DW-1:0])));
      end
   end
endmodule

// File: tb/opnd_xbar_bench.sv
module opnd_xbar_bench;
   localparam int NSLOT  = 8;
   localparam int DW     = 32;
   localparam int NPOS   = 16;
   localparam int NSTORE = 16;
   localparam int POS_W  = 4;
   localparam int NOP    = 2*NSLOT;
   localparam logic [2*NSLOT-1:0] CAP = 16'h0AAA;
   localparam int NCYC   = 3000;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic [NSLOT-1:0]        fresh_vld;
   logic [NSLOT*DW-1:0]     fresh_data;
   logic [NSTORE-1:0]       store_vld;
   logic [NSTORE*POS_W-1:0] store_pos;
   logic [NSTORE*DW-1:0]    store_data;
   logic [2*NSLOT-1:0]      req_cnt;
   logic [NOP*POS_W-1:0]    req_pos;
   logic [NOP*DW-1:0]       op_data;
   logic [NOP-1:0]          op_vld;

   opnd_xbar #(.NSLOT(NSLOT), .DW(DW), .NPOS(NPOS), .NSTORE(NSTORE),
               .SLOT_CAP(CAP)) u_opnd_xbar (
      .clk(clk), .rst_n(rst_n), .fresh_vld(fresh_vld), .fresh_data(fresh_data),
      .store_vld(store_vld), .store_pos(store_pos), .store_data(store_data),
      .req_cnt(req_cnt), .req_pos(req_pos), .op_data(op_data), .op_vld(op_vld)
   );

   always #4ns clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [DW-1:0] belt [NPOS];
   int            occ;
   logic [DW-1:0] exp_d [NOP];
   logic          exp_v [NOP];
   string         exp_t [NOP];

   task automatic check_one(input int o, input string tag,
                            input logic v, input logic [DW-1:0] d);
      checks++;
      if (op_vld[o] !== v || op_data[o*DW +: DW] !== d) begin
         fails++;
         $display("FAIL %s operand %0d: got vld=%0b data=%h, expected vld=%0b data=%h",
                  tag, o, op_vld[o], op_data[o*DW +: DW], v, d);
      end
   endtask

   task automatic check_all();
      for (int o = 0; o < NOP; o++) check_one(o, exp_t[o], exp_v[o], exp_d[o]);
   endtask

   // mode 0 random, 1 all fresh, 2 no fresh, 3 boundary positions k and k-1
   task automatic drive(input int mode);
      logic [DW-1:0] nb [NPOS];
      int k, idx, nocc, rot;
      case (mode)
         1:       fresh_vld = '1;
         2:       fresh_vld = '0;
         default: fresh_vld = NSLOT'($urandom);
      endcase
      for (int s = 0; s < NSLOT; s++) fresh_data[s*DW +: DW] = $urandom;
      rot = $urandom % NPOS;
      for (int e = 0; e < NSTORE; e++) begin
         int p;
         p = (e + rot) % NPOS;
         if (p < occ) begin
            store_vld[e] = 1'b1;
            store_pos[e*POS_W +: POS_W] = POS_W'(p);
            store_data[e*DW +: DW] = belt[p];
         end else begin
            store_vld[e] = 1'b0;
            store_pos[e*POS_W +: POS_W] = POS_W'($urandom);
            store_data[e*DW +: DW] = $urandom;
         end
      end
      // belt after the drop
      k = 0; idx = 0;
      for (int s = 0; s < NSLOT; s++)
         if (fresh_vld[s]) begin nb[idx] = fresh_data[s*DW +: DW]; idx++; k++; end
      for (int i = 0; idx < NPOS; i++) begin nb[idx] = belt[i]; idx++; end
      nocc = (occ + k > NPOS) ? NPOS : occ + k;
      for (int s = 0; s < NSLOT; s++) begin
         int cnt, cap, eff;
         cnt = (mode == 3) ? 2 : ($urandom % 4);
         req_cnt[2*s +: 2] = 2'(cnt);
         cap = int'(CAP[2*s +: 2]);
         if (cap > 2) cap = 2;
         if (cnt > 2) cnt = 2;
         eff = (cnt < cap) ? cnt : cap;
         for (int j = 0; j < 2; j++) begin
            int o, p;
            o = 2*s + j;
            if (mode == 3) p = (j == 0) ? k : ((k > 0) ? k - 1 : 0);
            else           p = $urandom % NPOS;
            if (p >= NPOS) p = NPOS - 1;
            req_pos[o*POS_W +: POS_W] = POS_W'(p);
            if (j >= cap)       exp_t[o] = "R8";
            else if (j >= cnt)  exp_t[o] = "R7";
            else if (p >= nocc) exp_t[o] = "R6";
            else if (p < k)     exp_t[o] = (p < occ) ? "R4" : "R3";
            else                exp_t[o] = "R5";
            exp_v[o] = (j < eff) && (p < nocc);
            exp_d[o] = exp_v[o] ? nb[p] : '0;
         end
      end
      for (int i = 0; i < NPOS; i++) belt[i] = nb[i];
      occ = nocc;
   endtask

   initial begin
      #(8ns * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C0A));
      rst_n = 1'b0; fresh_vld = '0; fresh_data = '0; store_vld = '0;
      store_pos = '0; store_data = '0; req_cnt = '0; req_pos = '0;
      occ = 0;
      for (int i = 0; i < NPOS; i++) belt[i] = '0;
      for (int o = 0; o < NOP; o++) begin exp_v[o] = 0; exp_d[o] = '0; exp_t[o] = "R1"; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_all();                         // R1 during reset
      rst_n = 1'b1;
      for (int c = 0; c < NCYC; c++) begin
         logic          pv;
         logic [DW-1:0] pd;
         int            mode;
         @(negedge clk);
         check_all();                      // R1 on first pass, then R3..R8
         pv = exp_v[0]; pd = exp_d[0];
         case (c)
            0, 4, 5: mode = 1;
            2:       mode = 2;
            1, 3:    mode = 3;
            default: mode = (c % 50 == 0) ? 3 : ((c % 37 == 0) ? 1 : ((c % 41 == 0) ? 2 : 0));
         endcase
         drive(mode);
         #1ns;
         check_one(0, "R2", pv, pd);       // R2: no change before the edge
      end
      @(negedge clk);
      check_all();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule